// File: doc/BRIEF.md
# Bit-Masked GPIO Port Controller

This block controls a parameterised port of general-purpose pins, 32 by default. Five word-wide registers sit on a simple register bus. Three mode registers together give every pin a 3-bit mode. A data register holds the output latch and, for pins in a pull mode, the pull direction. A protect mask guards the other four registers. Any bit set in the protect mask freezes the matching bit of the mode and data registers during a write. Software can therefore change single pins without a read-modify-write sequence that an interrupt could split.

For each pin the block decodes the mode into pad controls: output enable, drive value, pull-up, pull-down, input-receiver enable and analog switch. The peripheral side supplies the alternate-function output value. It receives the sampled pin value back on `af_in`. A single `conv_busy` input marks an analog conversion in progress. The `standby` input parks the port: every pad goes high-impedance except for input sampling on one wake pin.

Top module: `mgpio_port`

## Requirements
- R1: After synchronous reset, every pin has mode 001 (mode register 0 all ones, mode registers 1 and 2 all zeros), the data register is 0 and the protect mask is 0.
- R2: A write to mode register 0, 1 or 2 or to the data register updates only the bits that are 0 in the protect mask. Bits that are 1 keep their old value.
- R3: A write to the protect mask at word address 4 loads all bits directly, whatever the mask currently holds.
- R4: A write takes effect only when all byte enables are 1. A write with any byte enable low leaves every register unchanged. Word addresses: 0, 1 and 2 are mode registers 0, 1 and 2; 3 is data; 4 is the mask. Other addresses read 0.
- R5: The mode of pin n is {mode2[n], mode1[n], mode0[n]}:
  - 000 analog
  - 001 or 010 floating input
  - 011 input with pull
  - 100 output open-drain
  - 101 output push-pull
  - 110 peripheral open-drain
  - 111 peripheral push-pull
- R6: The drive source is the data bit for modes 10x and `af_out` for modes 11x.
  - Push-pull modes set `pad_oe`=1 and `pad_out`=source.
  - Open-drain modes set `pad_out`=0 and `pad_oe`=NOT source.
  - Input and analog modes set `pad_oe`=0.
- R7: In mode 011, a data bit of 1 enables only the pull-up and a data bit of 0 enables only the pull-down. In every other mode both pulls are off.
- R8: The input receiver is enabled in every mode except analog. The input latch samples `pin_in` on every clock while the receiver is enabled, and is 0 after any clock with the receiver disabled. `af_in` is the input latch.
- R9: `ana_sw` of a pin equals `conv_busy` while that pin is in analog mode, and is 0 otherwise.
- R10: A read of the data register returns the data latch for pins in modes 101 and 111, and the input latch for every other mode.
- R11: While `standby` is 1, all outputs enables, pulls and analog switches are 0. Only pin WAKE_PIN (default 0) keeps its receiver enabled, so every other pin's input latch reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_be | input | 4 | Byte enables; all must be set for a write |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| pin_in | input | 32 | Pad receiver values |
| af_out | input | 32 | Peripheral drive values |
| af_in | output | 32 | Input latch towards peripherals |
| conv_busy | input | 1 | Analog conversion in progress |
| standby | input | 1 | Park all pads |
| pad_oe | output | 32 | Pad output enable |
| pad_out | output | 32 | Pad drive value |
| pull_up | output | 32 | Weak pull-up enable |
| pull_dn | output | 32 | Weak pull-down enable |
| schmitt_en | output | 32 | Input receiver enable |
| ana_sw | output | 32 | Analog switch closed |

## Verification
The bench walks every mode with the data bit, peripheral value and pin value chosen so that each one changes the expected outcome. A design that swapped the open-drain sense or picked the wrong drive source would drive a pin it should release. One that read the data latch in an open-drain mode would return the written value instead of the pin. Masked writes are checked on mode and data registers with a mask that changes between writes. A mask that also guarded itself shows up in this check, and so does a wrong merge order. A partial-width write is checked to change nothing. In standby the bench checks that a push-pull pin is released and that only the wake pin keeps reporting its input. After a conversion ends, analog pins are checked to return 0 rather than a stale sample.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

    typedef enum logic [2:0] {
        MODE_ANALOG  = 3'b000,
        MODE_FLOAT_A = 3'b001,
        MODE_FLOAT_B = 3'b010,
        MODE_PULL    = 3'b011,
        MODE_OUT_OD  = 3'b100,
        MODE_OUT_PP  = 3'b101,
        MODE_ALT_OD  = 3'b110,
        MODE_ALT_PP  = 3'b111
    } pin_mode_e;

    localparam int REG_ADDR_W = 3;
    localparam int NUM_MASKED = 4;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_MODE0 = 3'd0,
        REG_MODE1 = 3'd1,
        REG_MODE2 = 3'd2,
        REG_DATA  = 3'd3,
        REG_MASK  = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic oe;
        logic drv;
        logic pu;
        logic pd;
        logic schmitt;
        logic ana;
        logic rd_latch;   // read returns data latch instead of input latch
    } pin_ctrl_t;

    function automatic pin_ctrl_t decode_pin(input logic [2:0] mode, input logic dat,
                                             input logic af, input logic busy,
                                             input logic stby, input logic wake);
        pin_ctrl_t c;
        logic      src;
        c   = '0;
        src = mode[1] ? af : dat;
        case (mode)
            MODE_ANALOG:               c.ana = busy;
            MODE_FLOAT_A, MODE_FLOAT_B: c.schmitt = 1'b1;
            MODE_PULL: begin
                c.schmitt = 1'b1;
                c.pu      = dat;
                c.pd      = ~dat;
            end
            default: begin
                c.schmitt = 1'b1;
                if (mode[0]) begin
                    c.oe       = 1'b1;
                    c.drv      = src;
                    c.rd_latch = 1'b1;
                end else begin
                    c.oe = ~src;
                end
            end
        endcase
        if (stby) begin
            c         = '0;
            c.schmitt = wake;
        end
        return c;
    endfunction

endpackage

// File: rtl/gpio_mask_regs.sv
module gpio_mask_regs
    import gpio_mask_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_go,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]          wr_data,
    output logic [W-1:0]          mode0_q,
    output logic [W-1:0]          mode1_q,
    output logic [W-1:0]          mode2_q,
    output logic [W-1:0]          data_q,
    output logic [W-1:0]          mask_q
);

    logic [NUM_MASKED-1:0][W-1:0] guarded_q;

    for (genvar g = 0; g < NUM_MASKED; g++) begin : g_guarded
        localparam logic [W-1:0] RST_VAL = (g == 0) ? '1 : '0;
        always_ff @(posedge clk) begin
            if (rst)
                guarded_q[g] <= RST_VAL;
            else if (wr_go && wr_addr == REG_ADDR_W'(g))
                guarded_q[g] <= (guarded_q[g] & mask_q) | (wr_data & ~mask_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else if (wr_go && wr_addr == REG_MASK)
            mask_q <= wr_data;
    end

    assign mode0_q = guarded_q[0];
    assign mode1_q = guarded_q[1];
    assign mode2_q = guarded_q[2];
    assign data_q  = guarded_q[3];

endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
    import gpio_mask_pkg::*;
#(
    parameter bit IS_WAKE = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic [2:0] mode,
    input  logic      dat,
    input  logic      af,
    input  logic      busy,
    input  logic      stby,
    input  logic      pin,
    output pin_ctrl_t ctrl,
    output logic      latch_q
);

    always_comb ctrl = decode_pin(mode, dat, af, busy, stby, IS_WAKE);

    always_ff @(posedge clk) begin
        if (rst)
            latch_q <= 1'b0;
        else
            latch_q <= pin & ctrl.schmitt;
    end

endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
    import gpio_mask_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [W-1:0]          mode0_q,
    input  logic [W-1:0]          mode1_q,
    input  logic [W-1:0]          mode2_q,
    input  logic [W-1:0]          data_q,
    input  logic [W-1:0]          mask_q,
    input  logic [W-1:0]          rd_latch,
    input  logic [W-1:0]          in_latch,
    output logic [W-1:0]          rdata
);

    always_comb begin
        case (reg_sel_e'(addr))
            REG_MODE0: rdata = mode0_q;
            REG_MODE1: rdata = mode1_q;
            REG_MODE2: rdata = mode2_q;
            REG_DATA:  rdata = (data_q & rd_latch) | (in_latch & ~rd_latch);
            REG_MASK:  rdata = mask_q;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/mgpio_port.sv
module mgpio_port
    import gpio_mask_pkg::*;
#(
    parameter int W        = 32,
    parameter int WAKE_PIN = 0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [W/8-1:0]        bus_be,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]          bus_wdata,
    output logic [W-1:0]          bus_rdata,
    input  logic [W-1:0]          pin_in,
    input  logic [W-1:0]          af_out,
    output logic [W-1:0]          af_in,
    input  logic                  conv_busy,
    input  logic                  standby,
    output logic [W-1:0]          pad_oe,
    output logic [W-1:0]          pad_out,
    output logic [W-1:0]          pull_up,
    output logic [W-1:0]          pull_dn,
    output logic [W-1:0]          schmitt_en,
    output logic [W-1:0]          ana_sw
);

    localparam int BE_W = W / 8;

    logic         wr_go;
    logic [W-1:0] mode0_q, mode1_q, mode2_q, data_q, mask_q;
    logic [W-1:0] in_latch, rd_latch;

    assign wr_go = bus_sel && bus_wr && (bus_be == {BE_W{1'b1}});

    gpio_mask_regs #(.W(W)) i_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_go   (wr_go),
        .wr_addr (bus_addr),
        .wr_data (bus_wdata),
        .mode0_q (mode0_q),
        .mode1_q (mode1_q),
        .mode2_q (mode2_q),
        .data_q  (data_q),
        .mask_q  (mask_q)
    );

    for (genvar gi = 0; gi < W; gi++) begin : g_pin
        pin_ctrl_t ctrl;
        gpio_pin_cell #(.IS_WAKE(gi == WAKE_PIN)) i_cell (
            .clk     (clk),
            .rst     (rst),
            .mode    ({mode2_q[gi], mode1_q[gi], mode0_q[gi]}),
            .dat     (data_q[gi]),
            .af      (af_out[gi]),
            .busy    (conv_busy),
            .stby    (standby),
            .pin     (pin_in[gi]),
            .ctrl    (ctrl),
            .latch_q (in_latch[gi])
        );
        assign pad_oe[gi]     = ctrl.oe;
        assign pad_out[gi]    = ctrl.drv;
        assign pull_up[gi]    = ctrl.pu;
        assign pull_dn[gi]    = ctrl.pd;
        assign schmitt_en[gi] = ctrl.schmitt;
        assign ana_sw[gi]     = ctrl.ana;
        assign rd_latch[gi]   = ctrl.rd_latch;
    end

    assign af_in = in_latch;

    gpio_read_mux #(.W(W)) i_rmux (
        .addr     (bus_addr),
        .mode0_q  (mode0_q),
        .mode1_q  (mode1_q),
        .mode2_q  (mode2_q),
        .data_q   (data_q),
        .mask_q   (mask_q),
        .rd_latch (rd_latch),
        .in_latch (in_latch),
        .rdata    (bus_rdata)
    );

endmodule

// File: rtl/mgpio_port_chk.sv
module mgpio_port_chk
    import gpio_mask_pkg::*;
#(
    parameter int W = 32
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  bus_sel,
    input logic                  bus_wr,
    input logic [W/8-1:0]        bus_be,
    input logic [REG_ADDR_W-1:0] bus_addr,
    input logic [W-1:0]          bus_wdata,
    input logic                  standby,
    input logic [W-1:0]          mode0_q,
    input logic [W-1:0]          mode1_q,
    input logic [W-1:0]          mode2_q,
    input logic [W-1:0]          data_q,
    input logic [W-1:0]          mask_q,
    input logic [W-1:0]          in_latch,
    input logic [W-1:0]          pad_oe,
    input logic [W-1:0]          pull_up,
    input logic [W-1:0]          pull_dn,
    input logic [W-1:0]          ana_sw
);

    logic         full_wr;
    logic [W-1:0] analog_live;

    assign full_wr     = bus_sel && bus_wr && (&bus_be);
    assign analog_live = ~mode2_q & ~mode1_q & ~mode0_q & {W{~standby}};

    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (mode0_q == '1 && mode1_q == '0 && mode2_q == '0 &&
                        data_q == '0 && mask_q == '0));

    assert_data_mask_R2: assert property (@(posedge clk) disable iff (rst)
        (full_wr && bus_addr == REG_DATA) |=>
            (((data_q ^ $past(data_q)) & $past(mask_q)) == '0));

    assert_mode1_mask_R2: assert property (@(posedge clk) disable iff (rst)
        (full_wr && bus_addr == REG_MODE1) |=>
            (((mode1_q ^ $past(mode1_q)) & $past(mask_q)) == '0));

    assert_mask_direct_R3: assert property (@(posedge clk) disable iff (rst)
        (full_wr && bus_addr == REG_MASK) |=> (mask_q == $past(bus_wdata)));

    assert_partial_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && !(&bus_be)) |=>
            ($stable(data_q) && $stable(mode0_q) && $stable(mode1_q) &&
             $stable(mode2_q) && $stable(mask_q)));

    assert_pull_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        ((pull_up & pull_dn) == '0) && (((pull_up | pull_dn) & mode2_q) == '0));

    assert_analog_zero_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(analog_live) & in_latch) == '0));

    assert_switch_mode_R9: assert property (@(posedge clk) disable iff (rst)
        ((ana_sw & ~analog_live) == '0));

    assert_standby_park_R11: assert property (@(posedge clk) disable iff (rst)
        standby |-> (pad_oe == '0 && pull_up == '0 && pull_dn == '0 && ana_sw == '0));

endmodule

bind mgpio_port mgpio_port_chk #(.W(W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_be    (bus_be),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .standby   (standby),
    .mode0_q   (mode0_q),
    .mode1_q   (mode1_q),
    .mode2_q   (mode2_q),
    .data_q    (data_q),
    .mask_q    (mask_q),
    .in_latch  (in_latch),
    .pad_oe    (pad_oe),
    .pull_up   (pull_up),
    .pull_dn   (pull_dn),
    .ana_sw    (ana_sw)
);

// File: tb/test_mgpio_port.sv
module test_mgpio_port;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst;
    logic         bus_sel, bus_wr;
    logic [3:0]   bus_be;
    logic [2:0]   bus_addr;
    logic [W-1:0] bus_wdata, bus_rdata;
    logic [W-1:0] pin_in, af_out, af_in;
    logic         conv_busy, standby;
    logic [W-1:0] pad_oe, pad_out, pull_up, pull_dn, schmitt_en, ana_sw;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    mgpio_port i_mgpio_port (
        .clk        (clk),
        .rst        (rst),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_be     (bus_be),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pin_in     (pin_in),
        .af_out     (af_out),
        .af_in      (af_in),
        .conv_busy  (conv_busy),
        .standby    (standby),
        .pad_oe     (pad_oe),
        .pad_out    (pad_out),
        .pull_up    (pull_up),
        .pull_dn    (pull_dn),
        .schmitt_en (schmitt_en),
        .ana_sw     (ana_sw)
    );

    // {mode[2:0], dat, af, pin, busy, oe, out, pu, pd, schmitt, ana, rd}
    localparam int NROWS = 14;
    localparam logic [13:0] ROWS [NROWS] = '{
        14'b000_1011_0000010,
        14'b000_1010_0000000,
        14'b001_0010_0000101,
        14'b010_1101_0000100,
        14'b011_1010_0010101,
        14'b011_0000_0001100,
        14'b100_0010_1000101,
        14'b100_1000_0000100,
        14'b101_1000_1100101,
        14'b101_0011_1000100,
        14'b110_1010_1000101,
        14'b110_0100_0000100,
        14'b111_0100_1100100,
        14'b111_1010_1000101
    };

    task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic set_mode(input logic [2:0] m);
        wr(3'd0, {W{m[0]}}, 4'hF);
        wr(3'd1, {W{m[1]}}, 4'hF);
        wr(3'd2, {W{m[2]}}, 4'hF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [W-1:0] v;
        rst = 1'b1; bus_sel = 1'b0; bus_wr = 1'b0; bus_be = 4'h0; bus_addr = '0;
        bus_wdata = '0; pin_in = '0; af_out = '0; conv_busy = 1'b0; standby = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, v); check("R1 mode0", 256'(v), 256'(32'hFFFF_FFFF));
        rd(3'd1, v); check("R1 mode1", 256'(v), 256'(0));
        rd(3'd2, v); check("R1 mode2", 256'(v), 256'(0));
        rd(3'd4, v); check("R1 mask", 256'(v), 256'(0));
        check("R1 outputs", 256'({pad_oe, pull_up, pull_dn, schmitt_en}),
              256'({96'(0), 32'hFFFF_FFFF}));

        // R3 mask loads directly, even when already set
        wr(3'd4, 32'h0000_FFFF, 4'hF);
        rd(3'd4, v); check("R3 mask load", 256'(v), 256'(32'h0000_FFFF));
        wr(3'd4, 32'hA5A5_A5A5, 4'hF);
        rd(3'd4, v); check("R3 mask overwrite", 256'(v), 256'(32'hA5A5_A5A5));

        // R2 masked mode-register writes
        wr(3'd4, 32'h0000_FFFF, 4'hF);
        wr(3'd1, 32'hFFFF_FFFF, 4'hF);
        rd(3'd1, v); check("R2 mode1 masked", 256'(v), 256'(32'hFFFF_0000));
        wr(3'd0, 32'h0000_0000, 4'hF);
        rd(3'd0, v); check("R2 mode0 masked", 256'(v), 256'(32'h0000_FFFF));

        // R2 masked data writes in push-pull output mode
        wr(3'd4, 32'h0, 4'hF);
        set_mode(3'b101);
        wr(3'd3, 32'h1234_5678, 4'hF);
        rd(3'd3, v); check("R2 data plain", 256'(v), 256'(32'h1234_5678));
        wr(3'd4, 32'hF0F0_F0F0, 4'hF);
        wr(3'd3, 32'hFFFF_FFFF, 4'hF);
        rd(3'd3, v); check("R2 data set", 256'(v), 256'(32'h1F3F_5F7F));
        wr(3'd3, 32'h0, 4'hF);
        rd(3'd3, v); check("R2 data clear", 256'(v), 256'(32'h1030_5070));
        check("R6 push-pull drive", 256'({pad_oe, pad_out}), 256'({32'hFFFF_FFFF, 32'h1030_5070}));

        // R4 partial writes ignored
        wr(3'd4, 32'h0, 4'hF);
        wr(3'd3, 32'h0, 4'b1110);
        rd(3'd3, v); check("R4 partial data", 256'(v), 256'(32'h1030_5070));
        wr(3'd4, 32'hFFFF_FFFF, 4'b0111);
        rd(3'd4, v); check("R4 partial mask", 256'(v), 256'(0));
        rd(3'd6, v); check("R4 unmapped read", 256'(v), 256'(0));

        // R5..R10 mode table
        for (int r = 0; r < NROWS; r++) begin
            logic [13:0] e;
            logic [W-1:0] rdv;
            logic         lat;
            e = ROWS[r];
            pin_in = {W{e[8]}}; af_out = {W{e[9]}}; conv_busy = e[7];
            set_mode(e[13:11]);
            wr(3'd3, {W{e[10]}}, 4'hF);
            @(negedge clk);
            rd(3'd3, rdv);
            check($sformatf("R5 R6 R7 R9 R10 row %0d", r),
                  256'({pad_oe, pad_out, pull_up, pull_dn, schmitt_en, ana_sw, rdv}),
                  256'({{W{e[6]}}, {W{e[5]}}, {W{e[4]}}, {W{e[3]}}, {W{e[2]}},
                        {W{e[1]}}, {W{e[0]}}}));
            lat = e[8] & e[2];
            check($sformatf("R8 input latch row %0d", r), 256'(af_in), 256'({W{lat}}));
        end
        conv_busy = 1'b0;

        // R11 standby
        pin_in = '1;
        set_mode(3'b101);
        wr(3'd3, 32'hFFFF_FFFF, 4'hF);
        standby = 1'b1;
        @(negedge clk);
        check("R11 standby release", 256'({pad_oe, pull_up, pull_dn, ana_sw}), 256'(0));
        set_mode(3'b011);
        check("R11 standby no pull", 256'({pull_up, pull_dn}), 256'(0));
        set_mode(3'b001);
        @(negedge clk);
        rd(3'd3, v); check("R11 wake pin only", 256'(v), 256'(32'h0000_0001));
        standby = 1'b0;
        repeat (2) @(negedge clk);
        rd(3'd3, v); check("R8 resume sampling", 256'(v), 256'(32'hFFFF_FFFF));

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule